// File: doc/BRIEF.md
# Triggered Event Acquisition Controller

This block runs the acquisition window of a 36-channel front-end. A pulse on the start input opens a window. It clears all event slots and sets a 12-bit bunch-crossing counter to zero. The counter then advances on each crossing strobe. A trigger comes from the OR of the 36 channel lines or from the external force input. The first trigger in a crossing claims the next free slot of sixteen. That slot records the current crossing number and the channel hit pattern, and a one-cycle hold pulse goes to the analog memory. Any later trigger in the same crossing only adds hit bits to the event already claimed.

When all sixteen slots are in use, the block pulls a shared open-drain full line low and stops acquiring. Other chips share this wired line, so an external chip that pulls it low also stops this block. A no-trigger input prevents any new slot from being claimed. A combinational read port gives the stored slots to the downstream conversion and readout logic.

Top module: `evt_acq_ctrl`

## Requirements
- R1: After reset, every slot reads as invalid, hold_o is low and the full line is released (high-impedance). Triggers are ignored until the first start pulse.
- R2: A start pulse marks every slot invalid, sets the crossing number to 0, clears the event count, releases the full line and opens the acquisition window. Triggers and strobes in the start cycle are ignored.
- R3: While the window is open, each cycle with bx_tick_i high advances the crossing number by one, and 4095 wraps to 0. A cycle with bx_tick_i high is the last cycle of the crossing that is ending, so a trigger in that cycle is stamped with the number from before the increment.
- R4: A trigger (any trig_i bit or force_i) in a crossing with no event yet claims slots in the order 0, 1, … 15. The slot stores the crossing number and hit pattern = trig_i, where bit n is channel n. A force-only event stores an all-zero pattern.
- R5: hold_o is high for exactly the one cycle after each cycle in which a slot is claimed, and is low at all other times.
- R6: Triggers in later cycles of the same crossing as a claimed event OR their trig_i bits into that event's pattern. They claim no new slot and raise no hold.
- R7: While no_trig_i is high, no slot is claimed. Merging into an event already open in the current crossing continues.
- R8: After the sixteenth claim, ram_full_no is driven to 0, the window closes, and later triggers change no slot and raise no hold.
- R9: If the shared full line (ram_full_bus_ni) is low while the window is open, the window closes in that cycle and nothing is claimed or merged until the next start.
- R10: The read port shows valid, crossing number and pattern of slot rd_slot_i combinationally. An invalid slot reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_start_i | input | 1 | Open a new acquisition window (one-cycle pulse) |
| bx_tick_i | input | 1 | Last cycle of the current bunch crossing |
| trig_i | input | 36 | Channel trigger lines |
| force_i | input | 1 | External force trigger |
| no_trig_i | input | 1 | Block new event allocation |
| ram_full_bus_ni | input | 1 | Sensed level of the shared full line |
| ram_full_no | output | 1 | Open-drain full drive: 0 or high-impedance |
| hold_o | output | 1 | Hold/valid pulse to the analog memory |
| rd_slot_i | input | 4 | Slot index to read |
| rd_valid_o | output | 1 | Selected slot holds an event |
| rd_bcid_o | output | 12 | Crossing number of the selected slot |
| rd_hits_o | output | 36 | Hit pattern of the selected slot |

## Verification
Directed sequences test a few cases separately. Triggers on the two outer channels in one cycle check the bit positions. A force trigger with no channel trigger separates the force path from the channel OR. Triggers spread over several cycles of one crossing, including the strobe cycle, separate merging from a new claim. A long run with no triggers followed by a trigger exposes the counter wrap. Sixteen fills, an external low on the full line, and no_trig_i held during a crossing test each way new events are stopped. Seeded random stimulus then mixes strobes, sparse multi-channel triggers, masking, restarts and external full pulses, and checks every slot against a bench model.

// File: rtl/evt_acq_pkg.sv
package evt_acq_pkg;
  localparam int unsigned CH_N   = 36;
  localparam int unsigned SLOT_N = 16;
  localparam int unsigned BCID_W = 12;
endpackage

// File: rtl/evt_bx_counter.sv
module evt_bx_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/evt_alloc_ctrl.sv
module evt_alloc_ctrl #(
  parameter int unsigned SLOT_N = 16,
  localparam int unsigned IW = $clog2(SLOT_N),
  localparam int unsigned CW = $clog2(SLOT_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          trig_any_i,
  input  logic          no_trig_i,
  input  logic          bus_low_i,
  output logic          acq_on_o,
  output logic          alloc_o,
  output logic          merge_o,
  output logic [IW-1:0] wr_slot_o,
  output logic [IW-1:0] mg_slot_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          hold_o,
  output logic          bx_en_o
);
  logic          acq_q, open_q, hold_q;
  logic [CW-1:0] cnt_q;
  logic          live;

  assign full_o    = (cnt_q == CW'(SLOT_N));
  assign live      = acq_q & ~start_i & ~bus_low_i;
  assign merge_o   = live & trig_any_i & open_q;
  assign alloc_o   = live & trig_any_i & ~open_q & ~no_trig_i & ~full_o;
  assign wr_slot_o = cnt_q[IW-1:0];
  assign mg_slot_o = IW'(cnt_q - 1'b1);
  assign bx_en_o   = acq_q & tick_i & ~start_i;
  assign acq_on_o  = acq_q;
  assign count_o   = cnt_q;
  assign hold_o    = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acq_q  <= 1'b0;
      open_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      acq_q  <= 1'b1;
      open_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= alloc_o;
      if (alloc_o) cnt_q <= cnt_q + 1'b1;
      if (acq_q && bus_low_i)                           acq_q <= 1'b0;
      else if (alloc_o && cnt_q == CW'(SLOT_N - 1))     acq_q <= 1'b0;
      // strobe cycle closes the crossing after any claim/merge in it
      if (acq_q && tick_i) open_q <= 1'b0;
      else if (alloc_o)    open_q <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_slot_store.sv
module evt_slot_store #(
  parameter int unsigned SLOT_N = 16,
  parameter int unsigned CH_N   = 36,
  parameter int unsigned BCID_W = 12,
  localparam int unsigned IW = $clog2(SLOT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              alloc_i,
  input  logic [IW-1:0]     wr_slot_i,
  input  logic              merge_i,
  input  logic [IW-1:0]     mg_slot_i,
  input  logic [BCID_W-1:0] bcid_i,
  input  logic [CH_N-1:0]   hits_i,
  input  logic [IW-1:0]     rd_slot_i,
  output logic              rd_valid_o,
  output logic [BCID_W-1:0] rd_bcid_o,
  output logic [CH_N-1:0]   rd_hits_o
);
  logic [SLOT_N-1:0] valid_q;
  logic [BCID_W-1:0] bcid_q [SLOT_N];
  logic [CH_N-1:0]   hits_q [SLOT_N];

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    logic wr_hit, mg_hit;
    assign wr_hit = alloc_i & (wr_slot_i == IW'(s));
    assign mg_hit = merge_i & (mg_slot_i == IW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[s] <= 1'b0;
        bcid_q[s]  <= '0;
        hits_q[s]  <= '0;
      end else if (clr_i) begin
        valid_q[s] <= 1'b0;
      end else if (wr_hit) begin
        valid_q[s] <= 1'b1;
        bcid_q[s]  <= bcid_i;
        hits_q[s]  <= hits_i;
      end else if (mg_hit) begin
        hits_q[s]  <= hits_q[s] | hits_i;
      end
    end
  end

  always_comb begin
    rd_valid_o = valid_q[rd_slot_i];
    rd_bcid_o  = rd_valid_o ? bcid_q[rd_slot_i] : '0;
    rd_hits_o  = rd_valid_o ? hits_q[rd_slot_i] : '0;
  end
endmodule

// File: rtl/evt_acq_ctrl.sv
module evt_acq_ctrl
  import evt_acq_pkg::*;
#(
  parameter int unsigned N_CH   = CH_N,
  parameter int unsigned N_SLOT = SLOT_N,
  parameter int unsigned BX_W   = BCID_W,
  localparam int unsigned IW = $clog2(N_SLOT),
  localparam int unsigned CW = $clog2(N_SLOT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acq_start_i,
  input  logic            bx_tick_i,
  input  logic [N_CH-1:0] trig_i,
  input  logic            force_i,
  input  logic            no_trig_i,
  input  logic            ram_full_bus_ni,
  output logic            ram_full_no,
  output logic            hold_o,
  input  logic [IW-1:0]   rd_slot_i,
  output logic            rd_valid_o,
  output logic [BX_W-1:0] rd_bcid_o,
  output logic [N_CH-1:0] rd_hits_o
);
  logic            trig_any, acq_on, alloc, merge, full, bx_en;
  logic [IW-1:0]   wr_slot, mg_slot;
  logic [CW-1:0]   count;
  logic [BX_W-1:0] bcid;

  assign trig_any = (|trig_i) | force_i;

  evt_bx_counter #(.W(BX_W)) i_bx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acq_start_i),
    .en_i   (bx_en),
    .cnt_o  (bcid)
  );

  evt_alloc_ctrl #(.SLOT_N(N_SLOT)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (acq_start_i),
    .tick_i     (bx_tick_i),
    .trig_any_i (trig_any),
    .no_trig_i  (no_trig_i),
    .bus_low_i  (~ram_full_bus_ni),
    .acq_on_o   (acq_on),
    .alloc_o    (alloc),
    .merge_o    (merge),
    .wr_slot_o  (wr_slot),
    .mg_slot_o  (mg_slot),
    .count_o    (count),
    .full_o     (full),
    .hold_o     (hold_o),
    .bx_en_o    (bx_en)
  );

  evt_slot_store #(.SLOT_N(N_SLOT), .CH_N(N_CH), .BCID_W(BX_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (acq_start_i),
    .alloc_i    (alloc),
    .wr_slot_i  (wr_slot),
    .merge_i    (merge),
    .mg_slot_i  (mg_slot),
    .bcid_i     (bcid),
    .hits_i     (trig_i),
    .rd_slot_i  (rd_slot_i),
    .rd_valid_o (rd_valid_o),
    .rd_bcid_o  (rd_bcid_o),
    .rd_hits_o  (rd_hits_o)
  );

  // open-drain: pull low or release
  assign ram_full_no = full ? 1'b0 : 1'bz;
endmodule

// File: rtl/evt_acq_chk.sv
module evt_acq_chk #(
  parameter int unsigned N_CH   = 36,
  parameter int unsigned N_SLOT = 16,
  localparam int unsigned CW = $clog2(N_SLOT + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            acq_start_i,
  input logic [N_CH-1:0] trig_i,
  input logic            force_i,
  input logic            no_trig_i,
  input logic            ram_full_bus_ni,
  input logic            hold_o,
  input logic            acq_on,
  input logic [CW-1:0]   count
);
  // R8
  full_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CW'(N_SLOT)) |-> !ram_full_bus_ni);

  // R8
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(N_SLOT));

  // R7
  no_trig_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_trig_i |=> !hold_o);

  // R5
  hold_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> $past((|trig_i) || force_i));

  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_i |=> (count == '0 && !hold_o && acq_on));

  // R9
  bus_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_on && !ram_full_bus_ni && !acq_start_i) |=> !acq_on);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acq_on && !acq_start_i) |=> !hold_o);
endmodule

bind evt_acq_ctrl evt_acq_chk #(.N_CH(N_CH), .N_SLOT(N_SLOT)) i_evt_acq_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .acq_start_i     (acq_start_i),
  .trig_i          (trig_i),
  .force_i         (force_i),
  .no_trig_i       (no_trig_i),
  .ram_full_bus_ni (ram_full_bus_ni),
  .hold_o          (hold_o),
  .acq_on          (acq_on),
  .count           (count)
);

// File: tb/test_evt_acq_ctrl.sv
`timescale 1ns/1ps
module test_evt_acq_ctrl;
  localparam int NC = 36;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 0, tick = 0, frc = 0, notrig = 0, ext_low = 0;
  logic [NC-1:0] trig = '0;
  logic [3:0]    rd_slot = '0;
  logic          hold, rd_valid;
  logic [11:0]   rd_bcid;
  logic [NC-1:0] rd_hits;
  wire           full_bus;

  pullup (full_bus);
  assign full_bus = ext_low ? 1'b0 : 1'bz;

  always #4 clk = ~clk;

  evt_acq_ctrl i_evt_acq_ctrl (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .acq_start_i     (start),
    .bx_tick_i       (tick),
    .trig_i          (trig),
    .force_i         (frc),
    .no_trig_i       (notrig),
    .ram_full_bus_ni (full_bus),
    .ram_full_no     (full_bus),
    .hold_o          (hold),
    .rd_slot_i       (rd_slot),
    .rd_valid_o      (rd_valid),
    .rd_bcid_o       (rd_bcid),
    .rd_hits_o       (rd_hits)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit          m_acq, m_open, m_hold;
  int          m_cnt;
  logic [11:0] m_bc;
  bit          m_val  [NS];
  logic [11:0] m_bcid [NS];
  logic [NC-1:0] m_hits [NS];

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acq = 0; m_open = 0; m_hold = 0; m_cnt = 0; m_bc = '0;
    for (int s = 0; s < NS; s++) begin
      m_val[s] = 0; m_bcid[s] = '0; m_hits[s] = '0;
    end
  endtask

  task automatic model_step();
    bit bus_low, any, alloc, acq_old;
    bus_low = ext_low || (m_cnt == NS);
    any     = (|trig) || frc;
    alloc   = 0;
    if (start) begin
      m_acq = 1; m_open = 0; m_hold = 0; m_cnt = 0; m_bc = '0;
      for (int s = 0; s < NS; s++) m_val[s] = 0;
    end else begin
      acq_old = m_acq;
      if (m_acq && !bus_low && any) begin
        if (m_open) m_hits[m_cnt-1] |= trig;
        else if (!notrig && m_cnt < NS) begin
          alloc = 1;
          m_val[m_cnt] = 1; m_bcid[m_cnt] = m_bc; m_hits[m_cnt] = trig;
          m_cnt++;
        end
      end
      m_hold = alloc;
      if (m_acq && bus_low) m_acq = 0;
      else if (alloc && m_cnt == NS) m_acq = 0;
      if (acq_old && tick) begin
        m_bc = m_bc + 12'd1; m_open = 0;
      end else if (alloc) m_open = 1;
    end
  endtask

  // drive at negedge, advance one edge, land on next negedge
  task automatic cyc(bit st, bit tk, logic [NC-1:0] tr, bit f, bit nt);
    start = st; tick = tk; trig = tr; frc = f; notrig = nt;
    model_step();
    @(posedge clk);
    @(negedge clk);
    start = 0; tick = 0; trig = '0; frc = 0; notrig = 0;
    check(hold === m_hold, "R5 hold", longint'(hold), longint'(m_hold));
    if (!ext_low)
      check(full_bus === (m_cnt == NS ? 1'b0 : 1'b1), "R8 full line",
            longint'(full_bus), longint'(m_cnt != NS));
  endtask

  task automatic check_slots(string req);
    for (int s = 0; s < NS; s++) begin
      rd_slot = 4'(s);
      #0.1;
      check(rd_valid === m_val[s], req, longint'(rd_valid), longint'(m_val[s]));
      check(rd_bcid === (m_val[s] ? m_bcid[s] : 12'd0), req,
            longint'(rd_bcid), longint'(m_val[s] ? m_bcid[s] : 12'd0));
      check(rd_hits === (m_val[s] ? m_hits[s] : '0), req,
            longint'(rd_hits), longint'(m_val[s] ? m_hits[s] : '0));
    end
  endtask

  function automatic logic [NC-1:0] bit_at(int n);
    return {{(NC-1){1'b0}}, 1'b1} << n;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hold === 1'b0, "R1 hold", longint'(hold), 0);
    check(full_bus === 1'b1, "R1 released", longint'(full_bus), 1);
    check_slots("R1 slots");
    cyc(0, 0, bit_at(3), 0, 0);          // ignored before start
    check_slots("R1 idle trigger");

    // R2 / R4 bit order, force-only
    cyc(1, 1, bit_at(1), 0, 0);          // start-cycle trigger ignored
    check_slots("R2 start");
    cyc(0, 0, bit_at(0) | bit_at(35), 0, 0);
    check(m_hold == 1, "R4 claim", longint'(hold), 1);
    cyc(0, 1, '0, 0, 0);
    cyc(0, 0, '0, 1, 0);                 // force only, crossing 1
    check_slots("R4 pattern");

    // R6 merge incl. strobe cycle, R3 stamping
    cyc(0, 1, '0, 0, 0);
    cyc(0, 0, bit_at(5), 0, 0);
    cyc(0, 0, bit_at(7), 0, 0);
    cyc(0, 1, bit_at(9), 0, 0);          // strobe cycle still merges
    cyc(0, 0, bit_at(11), 0, 0);         // new crossing, new slot
    check_slots("R6 merge");

    // R7 mask with merge still allowed
    cyc(0, 0, bit_at(12), 0, 1);         // open event: merges
    cyc(0, 1, '0, 0, 0);
    cyc(0, 0, bit_at(13), 1, 1);         // blocked
    cyc(0, 0, bit_at(14), 0, 1);
    check_slots("R7 no_trig");

    // R8 fill to 16
    while (m_cnt < NS) cyc(0, 1, bit_at(m_cnt), 0, 0);
    check(full_bus === 1'b0, "R8 pulled low", longint'(full_bus), 0);
    cyc(0, 1, bit_at(20), 1, 0);
    cyc(0, 0, bit_at(21), 0, 0);
    check_slots("R8 full");

    // R2 restart releases, R9 external low
    cyc(1, 0, '0, 0, 0);
    check(full_bus === 1'b1, "R2 release", longint'(full_bus), 1);
    cyc(0, 0, bit_at(2), 0, 0);
    ext_low = 1;
    cyc(0, 1, bit_at(4), 0, 0);
    ext_low = 0;
    cyc(0, 1, bit_at(6), 1, 0);
    cyc(0, 0, bit_at(8), 0, 0);
    check_slots("R9 external full");

    // R3 wrap
    cyc(1, 0, '0, 0, 0);
    for (int i = 0; i < 4095; i++) cyc(0, 1, '0, 0, 0);
    cyc(0, 0, bit_at(30), 0, 0);         // stamp 4095
    cyc(0, 1, '0, 0, 0);                 // wrap to 0
    cyc(0, 0, bit_at(31), 0, 0);
    check_slots("R3 wrap");

    // random mix, R10 read port on every sweep
    for (int i = 0; i < 6000; i++) begin
      logic [NC-1:0] tr;
      tr = '0;
      if ($urandom_range(0, 3) == 0)
        for (int k = 0; k < 3; k++)
          if ($urandom_range(0, 1) == 1) tr |= bit_at($urandom_range(0, NC-1));
      ext_low = ($urandom_range(0, 299) == 0);
      cyc(($urandom_range(0, 199) == 0), ($urandom_range(0, 2) == 0), tr,
          ($urandom_range(0, 19) == 0), ($urandom_range(0, 9) == 0));
      ext_low = 0;
      if (i % 250 == 249) check_slots("R10 random");
    end
    check_slots("R10 final");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule